// File: doc/BRIEF.md
# Dual-Bank Transmit Packet Buffer

This block holds outgoing packets for one bulk-IN style endpoint of a USB device controller. It has two storage banks, and each bank holds one packet of up to `PKT_MAX` bytes.

Software or a DMA engine fills the current write bank through a byte-wide port. A write-one trigger then commits the bytes written so far as one packet and moves the write side to the other bank. The serial side presents committed packets one byte at a time, together with their length and a last-byte marker, while the other bank is being filled.

A successful transfer is reported with an acknowledge, which frees the bank. A failed transfer is reported with a negative acknowledge, which replays the same bank from its first byte. A clear input throws away everything written and committed. A DMA request output tells the filling agent when a byte will be accepted.

Top module: `pp_txbuf`

## Requirements
- R1: After reset `tx_valid`=0, `buf_full`=0, `ovf`=0 and `dma_req`=1.
- R2: A pulse on `pkt_commit` makes a packet whose `tx_len` equals the number of bytes accepted in that bank since its last commit. A write in the commit cycle is included. A zero-length packet presents `tx_len`=0 with `tx_last`=1.
- R3: The bus side shows byte index `k` of the current packet on `tx_data`, starting at k=0. Each `tx_pop` while k<`tx_len` advances k by one. `tx_last` is 1 when k+1 >= `tx_len`.
- R4: A commit moves the write side to the other bank, so a second packet can be written and committed while the first is still held.
- R5: When both banks are committed and unsent, `buf_full`=1 and `dma_req`=0. Writes are dropped and set `ovf`, and `pkt_commit` has no effect.
- R6: `tx_ack` while `tx_valid`=1 frees the current bank. The next packet presented is the one committed next, so packets go out in commit order.
- R7: `tx_nak` while `tx_valid`=1 (and no `tx_ack`) returns k to 0, keeps the packet and keeps its length.
- R8: A write into a bank that already holds `PKT_MAX` bytes is dropped and sets `ovf`. `ovf` stays set until a clear, and the packet length saturates at `PKT_MAX`.
- R9: `buf_clr` empties both banks and returns to the reset state of R1. The write count restarts at zero.
- R10: `dma_req` is 1 exactly when the write bank is not committed and holds fewer than `PKT_MAX` bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| buf_clr | input | 1 | Discard all buffered data |
| wr_en | input | 1 | Byte write strobe (CPU or DMA) |
| wr_data | input | DW | Byte to store |
| pkt_commit | input | 1 | Write-one trigger that commits the write bank |
| dma_req | output | 1 | Write bank can accept a byte |
| buf_full | output | 1 | Both banks committed and unsent |
| ovf | output | 1 | Sticky dropped-write flag |
| tx_valid | output | 1 | A committed packet is presented |
| tx_len | output | CW | Length of the presented packet |
| tx_data | output | DW | Current byte of the presented packet |
| tx_last | output | 1 | Current byte is the final one |
| tx_pop | input | 1 | Advance to the next byte |
| tx_ack | input | 1 | Transfer succeeded, free the bank |
| tx_nak | input | 1 | Transfer failed, replay from the first byte |

## Verification
The bench replays a packet after partly popping it, and checks that the first byte returns. A design that keeps the read offset, or frees the bank on a failed transfer, would show the wrong byte or the next packet.

It fills both banks and then writes and commits again. A design that accepts in that state would corrupt a held packet, change its length or keep requesting DMA.

It also checks zero-length packets, which must flag the last byte at once, and a 70-byte burst. A counter that wraps would produce a short length and lose the sticky overflow. Finally it clears the buffer while a packet is held, and a design that forgets the write count would then give a stale length.

// File: rtl/pp_txbuf_pkg.sv
package pp_txbuf_pkg;
    localparam int unsigned PKT_MAX_DEF = 64;
    localparam int unsigned DW_DEF      = 8;
    localparam int unsigned NBANK       = 2;

    function automatic int unsigned cnt_w(input int unsigned max_bytes);
        return $clog2(max_bytes + 1);
    endfunction

    function automatic int unsigned addr_w(input int unsigned max_bytes);
        return (max_bytes > 1) ? $clog2(max_bytes) : 1;
    endfunction
endpackage

// File: rtl/pp_txbuf_mem.sv
module pp_txbuf_mem #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned DW    = 8,
    parameter int unsigned AW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          wbank,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rbank,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    import pp_txbuf_pkg::*;

    logic [DW-1:0] rd_word [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [DEPTH-1:0][DW-1:0] bank_d, bank_q;

        always_comb begin
            bank_d = bank_q;
            if (we && (wbank == b[0])) begin
                bank_d[waddr] = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bank_q <= '0;
            else        bank_q <= bank_d;
        end

        assign rd_word[b] = bank_q[raddr];
    end

    assign rdata = rd_word[rbank];
endmodule

// File: rtl/pp_txbuf_wrside.sv
module pp_txbuf_wrside #(
    parameter int unsigned PKT_MAX = 64,
    parameter int unsigned CW      = 7,
    parameter int unsigned AW      = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic          pkt_commit,
    input  logic [1:0]    busy,
    output logic          wsel,
    output logic [AW-1:0] waddr,
    output logic          wr_accept,
    output logic          commit_fire,
    output logic [CW-1:0] commit_len,
    output logic          dma_req,
    output logic          ovf
);
    typedef struct packed {
        logic          sel;
        logic [CW-1:0] cnt;
        logic          ovf;
    } wst_t;

    wst_t          st_d, st_q;
    logic          room;
    logic [CW-1:0] cnt_after;

    always_comb begin
        st_d        = st_q;
        room        = !busy[st_q.sel] && (st_q.cnt < CW'(PKT_MAX));
        wr_accept   = wr_en && room && !clr;
        cnt_after   = st_q.cnt + CW'(wr_accept);
        commit_fire = pkt_commit && !busy[st_q.sel] && !clr;
        if (clr) begin
            st_d = '0;
        end else begin
            if (wr_en && !wr_accept) st_d.ovf = 1'b1;
            if (commit_fire) begin
                st_d.sel = !st_q.sel;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = cnt_after;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wsel       = st_q.sel;
    assign waddr      = st_q.cnt[AW-1:0];
    assign commit_len = cnt_after;
    assign dma_req    = room;
    assign ovf        = st_q.ovf;

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !clr) |=> st_q.ovf);
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(PKT_MAX));
    p_commit_swaps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_fire |=> (st_q.sel != $past(st_q.sel)) && (st_q.cnt == '0));
endmodule

// File: rtl/pp_txbuf_rdside.sv
module pp_txbuf_rdside #(
    parameter int unsigned CW = 7,
    parameter int unsigned AW = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic [1:0]          busy,
    input  logic [1:0][CW-1:0]  lens,
    input  logic                tx_pop,
    input  logic                tx_ack,
    input  logic                tx_nak,
    output logic                rsel,
    output logic [AW-1:0]       raddr,
    output logic                tx_valid,
    output logic                tx_last,
    output logic [CW-1:0]       tx_len,
    output logic                release_fire
);
    typedef struct packed {
        logic          sel;
        logic [CW-1:0] ptr;
    } rst_t;

    rst_t          st_d, st_q;
    logic [CW-1:0] cur_len;

    always_comb begin
        st_d         = st_q;
        cur_len      = lens[st_q.sel];
        tx_valid     = busy[st_q.sel];
        release_fire = tx_valid && tx_ack && !clr;
        tx_last      = tx_valid &&
                       (({1'b0, st_q.ptr} + (CW+1)'(1)) >= {1'b0, cur_len});
        if (clr) begin
            st_d = '0;
        end else if (release_fire) begin
            st_d.sel = !st_q.sel;
            st_d.ptr = '0;
        end else if (tx_valid && tx_nak) begin
            st_d.ptr = '0;
        end else if (tx_valid && tx_pop && (st_q.ptr < cur_len)) begin
            st_d.ptr = st_q.ptr + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsel   = st_q.sel;
    assign raddr  = st_q.ptr[AW-1:0];
    assign tx_len = cur_len;

    p_ptr_in_pkt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (st_q.ptr <= cur_len));
    p_nak_rewind_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_nak && !tx_ack && !clr) |=> (st_q.ptr == '0) && tx_valid);
    p_ack_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
        release_fire |=> (st_q.sel != $past(st_q.sel)) && (st_q.ptr == '0));
endmodule

// File: rtl/pp_txbuf.sv
module pp_txbuf #(
    parameter int unsigned PKT_MAX = pp_txbuf_pkg::PKT_MAX_DEF,
    parameter int unsigned DW      = pp_txbuf_pkg::DW_DEF,
    localparam int unsigned CW     = pp_txbuf_pkg::cnt_w(PKT_MAX),
    localparam int unsigned AW     = pp_txbuf_pkg::addr_w(PKT_MAX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          buf_clr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          pkt_commit,
    output logic          dma_req,
    output logic          buf_full,
    output logic          ovf,
    output logic          tx_valid,
    output logic [CW-1:0] tx_len,
    output logic [DW-1:0] tx_data,
    output logic          tx_last,
    input  logic          tx_pop,
    input  logic          tx_ack,
    input  logic          tx_nak
);
    typedef struct packed {
        logic [1:0]         busy;
        logic [1:0][CW-1:0] len;
    } bst_t;

    bst_t          st_d, st_q;
    logic          wsel, rsel;
    logic [AW-1:0] waddr, raddr;
    logic          wr_accept, commit_fire, release_fire;
    logic [CW-1:0] commit_len;

    pp_txbuf_wrside #(.PKT_MAX(PKT_MAX), .CW(CW), .AW(AW)) u_wr (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(wr_en),
        .pkt_commit(pkt_commit), .busy(st_q.busy), .wsel(wsel),
        .waddr(waddr), .wr_accept(wr_accept), .commit_fire(commit_fire),
        .commit_len(commit_len), .dma_req(dma_req), .ovf(ovf)
    );

    pp_txbuf_rdside #(.CW(CW), .AW(AW)) u_rd (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .busy(st_q.busy),
        .lens(st_q.len), .tx_pop(tx_pop), .tx_ack(tx_ack), .tx_nak(tx_nak),
        .rsel(rsel), .raddr(raddr), .tx_valid(tx_valid), .tx_last(tx_last),
        .tx_len(tx_len), .release_fire(release_fire)
    );

    pp_txbuf_mem #(.DEPTH(PKT_MAX), .DW(DW), .AW(AW)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(wr_accept), .wbank(wsel),
        .waddr(waddr), .wdata(wr_data), .rbank(rsel), .raddr(raddr),
        .rdata(tx_data)
    );

    always_comb begin
        st_d = st_q;
        if (buf_clr) begin
            st_d = '0;
        end else begin
            if (commit_fire) begin
                st_d.busy[wsel] = 1'b1;
                st_d.len[wsel]  = commit_len;
            end
            if (release_fire) begin
                st_d.busy[rsel] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign buf_full = &st_q.busy;

    p_full_blocks_dma_r5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full |-> !dma_req);
    p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        buf_clr |=> (!tx_valid && !buf_full && !ovf));
    p_commit_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        commit_fire |=> tx_valid);
endmodule

// File: tb/pp_txbuf_bench.sv
module pp_txbuf_bench;
    localparam int unsigned PKT_MAX = 64;
    localparam int unsigned DW      = 8;
    localparam int unsigned CW      = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          buf_clr = 1'b0, wr_en = 1'b0, pkt_commit = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          tx_pop = 1'b0, tx_ack = 1'b0, tx_nak = 1'b0;
    logic          dma_req, buf_full, ovf, tx_valid, tx_last;
    logic [CW-1:0] tx_len;
    logic [DW-1:0] tx_data;

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] byte_q[$];
    int            len_q[$];

    always #4 clk = ~clk;

    pp_txbuf #(.PKT_MAX(PKT_MAX), .DW(DW)) u_pp_txbuf (
        .clk(clk), .rst_n(rst_n), .buf_clr(buf_clr), .wr_en(wr_en),
        .wr_data(wr_data), .pkt_commit(pkt_commit), .dma_req(dma_req),
        .buf_full(buf_full), .ovf(ovf), .tx_valid(tx_valid), .tx_len(tx_len),
        .tx_data(tx_data), .tx_last(tx_last), .tx_pop(tx_pop),
        .tx_ack(tx_ack), .tx_nak(tx_nak)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver: one byte, pushed to the scoreboard when it should be kept
    task automatic wr_byte(input logic [DW-1:0] d, input bit keep);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (keep) byte_q.push_back(d);
    endtask

    task automatic commit(input int n);
        pkt_commit = 1'b1;
        @(negedge clk);
        pkt_commit = 1'b0;
        len_q.push_back(n);
    endtask

    task automatic send_pkt(input int n, input logic [DW-1:0] base);
        for (int i = 0; i < n; i++) wr_byte(base + DW'(i), i < int'(PKT_MAX));
        commit((n > int'(PKT_MAX)) ? int'(PKT_MAX) : n);
    endtask

    // monitor: pops the scoreboard and compares against the bus side
    task automatic drain_pkt();
        int n;
        logic [DW-1:0] e;
        n = len_q.pop_front();
        check("R6 tx_valid", int'(tx_valid), 1);
        check("R2 tx_len", int'(tx_len), n);
        if (n == 0) check("R2 zero-length tx_last", int'(tx_last), 1);
        for (int i = 0; i < n; i++) begin
            e = byte_q.pop_front();
            check("R3 tx_data", int'(tx_data), int'(e));
            check("R3 tx_last", int'(tx_last), int'(i == n - 1));
            tx_pop = 1'b1;
            @(negedge clk);
            tx_pop = 1'b0;
        end
        tx_ack = 1'b1;
        @(negedge clk);
        tx_ack = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 tx_valid", int'(tx_valid), 0);
        check("R1 buf_full", int'(buf_full), 0);
        check("R1 ovf", int'(ovf), 0);
        check("R1 dma_req", int'(dma_req), 1);

        send_pkt(5, 8'h10);
        check("R2 tx_len after commit", int'(tx_len), 5);
        check("R10 dma_req other bank free", int'(dma_req), 1);

        send_pkt(3, 8'h40);
        check("R4 first packet still shown", int'(tx_len), 5);
        check("R5 buf_full", int'(buf_full), 1);
        check("R10 dma_req when full", int'(dma_req), 0);
        wr_byte(8'hEE, 1'b0);
        check("R5 write while full sets ovf", int'(ovf), 1);
        pkt_commit = 1'b1; @(negedge clk); pkt_commit = 1'b0;
        check("R5 commit ignored when full", int'(buf_full), 1);
        check("R5 length unchanged", int'(tx_len), 5);

        // partial send then failed transfer
        tx_pop = 1'b1; @(negedge clk); @(negedge clk); tx_pop = 1'b0;
        check("R3 byte two", int'(tx_data), int'(byte_q[2]));
        tx_nak = 1'b1; @(negedge clk); tx_nak = 1'b0;
        check("R7 rewind to first byte", int'(tx_data), int'(byte_q[0]));
        check("R7 length kept", int'(tx_len), 5);
        check("R7 still valid", int'(tx_valid), 1);

        drain_pkt();
        check("R6 buf_full after ack", int'(buf_full), 0);
        check("R6 second packet length", int'(tx_len), 3);
        check("R8 ovf sticky", int'(ovf), 1);
        drain_pkt();
        check("R6 empty after both", int'(tx_valid), 0);

        commit(0);
        drain_pkt();

        buf_clr = 1'b1; @(negedge clk); buf_clr = 1'b0;
        check("R9 ovf cleared", int'(ovf), 0);

        send_pkt(70, 8'h80);
        check("R8 ovf on overflow", int'(ovf), 1);
        drain_pkt();
        send_pkt(64, 8'h00);
        check("R10 dma_req bank free after commit", int'(dma_req), 1);
        for (int i = 0; i < 64; i++) wr_byte(8'hA0 + 8'(i), 1'b0);
        check("R10 dma_req at bank limit", int'(dma_req), 0);

        buf_clr = 1'b1; @(negedge clk); buf_clr = 1'b0;
        byte_q.delete(); len_q.delete();
        check("R9 tx_valid", int'(tx_valid), 0);
        check("R9 buf_full", int'(buf_full), 0);
        check("R9 dma_req", int'(dma_req), 1);
        check("R9 ovf", int'(ovf), 0);
        send_pkt(2, 8'h55);
        drain_pkt();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule